// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations for 4 KiB pages. A lookup takes a virtual address and the current context identifier. One cycle later it returns either a hit with the translated physical address, or a request for a hardware page walk. Each cached translation carries the context identifier it belongs to and a global flag. Several address spaces can therefore share the buffer, and entries that every context uses stay resident when the context changes.

Page walks happen outside the block. When the walker has the translation for a missed access, it writes it in through the fill port, and the access is then retried. Software maintenance arrives as two control inputs. One drops the translation for a single page. The other signals a reload of the page-table base register, which drops every entry that is not global. A paging-enable input turns translation off, and addresses then pass straight through.

Top module: `tagged_tlb`

## Requirements
- R1: A synchronous reset clears every valid bit and the result outputs. No lookup hits until a fill has installed a translation.
- R2: With `paging_en` high, a lookup sampled at a clock edge hits when a valid entry has the same page number (address bits above bit 11) and is either global or tagged with `cur_ctx`. The result appears after that edge: `res_valid` and `res_hit` are high and `res_paddr` is {stored frame number, address bits 11:0}. If several entries match, the lowest-numbered slot supplies the frame.
- R3: A translated lookup that finds no match gives `res_valid` and `walk_req` high, `res_hit` low and `res_paddr` zero. `res_hit` and `walk_req` are never high together.
- R4: A non-global entry matches only when its stored context equals `cur_ctx`. A global entry matches under any context.
- R5: An accepted fill writes page, context, frame and global flag into the lowest-numbered empty slot and makes it valid from the next cycle.
- R6: When no slot is empty, a fill replaces the slot named by a rotating pointer (starting at slot 0 after reset). The pointer moves to the next slot, wrapping after the last, only on such a replacing fill.
- R7: A page invalidate removes every valid entry whose page number equals `inv_vpn` and that is either global or tagged with `cur_ctx`. Entries of other contexts for that page survive.
- R8: A `base_write` pulse clears every valid non-global entry and keeps global entries. A fill in the same cycle is still installed.
- R9: When a fill and a page invalidate in the same cycle name the same page number, the fill is dropped and the rotating pointer does not move.
- R10: With `paging_en` low, a lookup returns `res_valid` high, `res_hit` and `walk_req` low, and `res_paddr` equal to the input address (zero-extended to the physical width).
- R11: In a cycle after which no lookup was sampled, `res_valid`, `res_hit` and `walk_req` are low and `res_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Translation enabled; low passes addresses through |
| cur_ctx | input | CTX_W | Current context identifier, used by lookup and page invalidate |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| res_valid | output | 1 | Registered: a lookup result is present |
| res_hit | output | 1 | Registered: the lookup hit |
| walk_req | output | 1 | Registered: the lookup missed and needs a page walk |
| res_paddr | output | PA_W | Registered physical address |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | VA_W-12 | Page number of the translation to install |
| fill_ctx | input | CTX_W | Context tag of the translation to install |
| fill_pfn | input | PA_W-12 | Physical frame number to install |
| fill_global | input | 1 | Translation to install is global |
| inv_valid | input | 1 | Invalidate one page this cycle |
| inv_vpn | input | VA_W-12 | Page number to invalidate |
| base_write | input | 1 | Page-table base reload: clear non-global entries |

## Verification
The bench builds the block with 4 entries, a 32-bit virtual address, a 36-bit physical address and a 4-bit context. With only four slots, replacement and wrap-around of the rotating pointer happen after a few fills. The physical width differs from the virtual width, so the frame concatenation and the zero-extension on bypass are both exercised. A random phase draws from eight pages and four contexts, which makes duplicate page numbers, context mismatches, fills colliding with invalidates and flushes racing with fills frequent. A behavioural model compares every result against the design.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Kind of result held in the output register
  typedef enum logic [1:0] {
    RK_IDLE   = 2'd0,
    RK_BYPASS = 2'd1,
    RK_HIT    = 2'd2,
    RK_MISS   = 2'd3
  } res_kind_e;
endpackage

// File: rtl/tlb_store.sv
// Entry storage: valid/global flags plus page, context and frame fields.
module tlb_store #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CTX_W = 12,
  parameter int IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fill_we,
  input  logic [IDX_W-1:0]           fill_slot,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [CTX_W-1:0]           fill_ctx,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic                       fill_glob,
  input  logic                       flush_ng,
  input  logic                       inv_en,
  input  logic [VPN_W-1:0]           inv_vpn,
  input  logic [CTX_W-1:0]           inv_ctx,
  output logic [N-1:0]               valid_o,
  output logic [N-1:0]               glob_o,
  output logic [N-1:0][VPN_W-1:0]    vpn_o,
  output logic [N-1:0][CTX_W-1:0]    ctx_o,
  output logic [N-1:0][PFN_W-1:0]    pfn_o
);
  logic [N-1:0]            valid_q;
  logic [N-1:0]            glob_q;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][CTX_W-1:0] ctx_q;
  logic [N-1:0][PFN_W-1:0] pfn_q;
  logic [N-1:0]            kill;
  logic [N-1:0]            wr;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      logic inv_hit;
      assign inv_hit = inv_en && valid_q[g] && (vpn_q[g] == inv_vpn) &&
                       (glob_q[g] || (ctx_q[g] == inv_ctx));
      assign kill[g] = inv_hit || (flush_ng && !glob_q[g]);
      assign wr[g]   = fill_we && (fill_slot == IDX_W'(g));
    end
  endgenerate

  // Flags: a write in the same cycle overrides any kill of that slot
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr[i])        valid_q[i] <= 1'b1;
        else if (kill[i]) valid_q[i] <= 1'b0;
      end
    end
  end

  // Payload: no reset needed, valid bit gates every use
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr[i]) begin
        glob_q[i] <= fill_glob;
        vpn_q[i]  <= fill_vpn;
        ctx_q[i]  <= fill_ctx;
        pfn_q[i]  <= fill_pfn;
      end
    end
  end

  assign valid_o = valid_q;
  assign glob_o  = glob_q;
  assign vpn_o   = vpn_q;
  assign ctx_o   = ctx_q;
  assign pfn_o   = pfn_q;
endmodule

// File: rtl/tlb_match.sv
// Parallel tag compare; lowest matching slot supplies the frame.
module tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CTX_W = 12
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0]            glob_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [N-1:0][CTX_W-1:0] ctx_i,
  input  logic [N-1:0][PFN_W-1:0] pfn_i,
  input  logic [VPN_W-1:0]        q_vpn,
  input  logic [CTX_W-1:0]        q_ctx,
  output logic                    hit,
  output logic [PFN_W-1:0]        hit_pfn
);
  logic [N-1:0] m;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign m[g] = valid_i[g] && (vpn_i[g] == q_vpn) &&
                    (glob_i[g] || (ctx_i[g] == q_ctx));
    end
  endgenerate

  always_comb begin
    hit_pfn = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) hit_pfn = pfn_i[i];
    end
  end

  assign hit = |m;
endmodule

// File: rtl/tlb_victim.sv
// Slot choice for fills: lowest empty slot, else rotating pointer.
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid_i,
  input  logic             take,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid_i;
  assign slot     = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && !any_free) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int CTX_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 paging_en,
  input  logic [CTX_W-1:0]     cur_ctx,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic                 walk_req,
  output logic [PA_W-1:0]      res_paddr,
  input  logic                 fill_valid,
  input  logic [VA_W-13:0]     fill_vpn,
  input  logic [CTX_W-1:0]     fill_ctx,
  input  logic [PA_W-13:0]     fill_pfn,
  input  logic                 fill_global,
  input  logic                 inv_valid,
  input  logic [VA_W-13:0]     inv_vpn,
  input  logic                 base_write
);
  import tlb_pkg::*;

  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid_vec;
  logic [ENTRIES-1:0]            glob_vec;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr;
  logic [ENTRIES-1:0][CTX_W-1:0] ctx_arr;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_arr;

  logic             fill_ok;
  logic [IDX_W-1:0] fill_slot;
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;

  // A same-page invalidate suppresses the fill
  assign fill_ok = fill_valid && !(inv_valid && (inv_vpn == fill_vpn));

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_vec),
    .take    (fill_ok),
    .slot    (fill_slot)
  );

  tlb_store #(
    .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W), .IDX_W(IDX_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .fill_we   (fill_ok),
    .fill_slot (fill_slot),
    .fill_vpn  (fill_vpn),
    .fill_ctx  (fill_ctx),
    .fill_pfn  (fill_pfn),
    .fill_glob (fill_global),
    .flush_ng  (base_write),
    .inv_en    (inv_valid),
    .inv_vpn   (inv_vpn),
    .inv_ctx   (cur_ctx),
    .valid_o   (valid_vec),
    .glob_o    (glob_vec),
    .vpn_o     (vpn_arr),
    .ctx_o     (ctx_arr),
    .pfn_o     (pfn_arr)
  );

  tlb_match #(
    .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)
  ) u_match (
    .valid_i (valid_vec),
    .glob_i  (glob_vec),
    .vpn_i   (vpn_arr),
    .ctx_i   (ctx_arr),
    .pfn_i   (pfn_arr),
    .q_vpn   (lk_vaddr[VA_W-1:OFF_W]),
    .q_ctx   (cur_ctx),
    .hit     (lk_hit),
    .hit_pfn (lk_pfn)
  );

  res_kind_e        kind_d, kind_q;
  logic [PA_W-1:0]  paddr_d, paddr_q;

  always_comb begin
    kind_d  = RK_IDLE;
    paddr_d = '0;
    if (lk_valid) begin
      if (!paging_en) begin
        kind_d  = RK_BYPASS;
        paddr_d = PA_W'(lk_vaddr);
      end else if (lk_hit) begin
        kind_d  = RK_HIT;
        paddr_d = {lk_pfn, lk_vaddr[OFF_W-1:0]};
      end else begin
        kind_d  = RK_MISS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= RK_IDLE;
      paddr_q <= '0;
    end else begin
      kind_q  <= kind_d;
      paddr_q <= paddr_d;
    end
  end

  assign res_valid = (kind_q != RK_IDLE);
  assign res_hit   = (kind_q == RK_HIT);
  assign walk_req  = (kind_q == RK_MISS);
  assign res_paddr = paddr_q;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         paging_en,
  input logic         lk_valid,
  input logic         fill_valid,
  input logic         inv_valid,
  input logic         base_write,
  input logic         res_valid,
  input logic         res_hit,
  input logic         walk_req,
  input logic [N-1:0] valid_vec,
  input logic [N-1:0] glob_vec
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && (valid_vec == '0)));

  // R3
  hit_walk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_hit && walk_req));

  // R2
  lookup_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && paging_en) |=> (res_valid && (res_hit || walk_req)));

  // R10
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !paging_en) |=> (res_valid && !res_hit && !walk_req));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && !res_hit && !walk_req));

  // R8
  flush_nonglobal_chk: assert property (@(posedge clk) disable iff (rst)
    (base_write && !fill_valid) |=> ((valid_vec & ~glob_vec) == '0));

  // R8
  flush_keeps_global_chk: assert property (@(posedge clk) disable iff (rst)
    (base_write && !fill_valid && !inv_valid) |=>
      ((valid_vec & glob_vec) == $past(valid_vec & glob_vec)));
endmodule

bind tagged_tlb tlb_chk #(.N(ENTRIES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .paging_en  (paging_en),
  .lk_valid   (lk_valid),
  .fill_valid (fill_valid),
  .inv_valid  (inv_valid),
  .base_write (base_write),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .walk_req   (walk_req),
  .valid_vec  (valid_vec),
  .glob_vec   (glob_vec)
);

// File: tb/test_tagged_tlb.sv
module test_tagged_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W  = 32;
  localparam int PA_W  = 36;
  localparam int CTX_W = 4;
  localparam int ENT   = 4;
  localparam int VPN_W = VA_W - 12;
  localparam int PFN_W = PA_W - 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             paging_en = 1'b1;
  logic [CTX_W-1:0] cur_ctx = '0;
  logic             lk_valid = 1'b0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             res_valid, res_hit, walk_req;
  logic [PA_W-1:0]  res_paddr;
  logic             fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [CTX_W-1:0] fill_ctx = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic             fill_global = 1'b0;
  logic             inv_valid = 1'b0;
  logic [VPN_W-1:0] inv_vpn = '0;
  logic             base_write = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_tlb #(.VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .ENTRIES(ENT)) i_tagged_tlb (
    .clk(clk), .rst(rst), .paging_en(paging_en), .cur_ctx(cur_ctx),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .res_valid(res_valid), .res_hit(res_hit), .walk_req(walk_req), .res_paddr(res_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
    .fill_pfn(fill_pfn), .fill_global(fill_global),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .base_write(base_write)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit               m_v [ENT];
  bit               m_g [ENT];
  logic [VPN_W-1:0] m_vpn [ENT];
  logic [CTX_W-1:0] m_ctx [ENT];
  logic [PFN_W-1:0] m_pfn [ENT];
  int               m_rr;
  bit               e_valid, e_hit, e_walk;
  logic [PA_W-1:0]  e_paddr;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENT; i++) m_v[i] = 0;
      m_rr = 0;
      e_valid = 0; e_hit = 0; e_walk = 0; e_paddr = '0;
    end else begin
      int  slot;
      bit  evict;
      bit  found;
      bit  take;
      e_valid = lk_valid; e_hit = 0; e_walk = 0; e_paddr = '0;
      if (lk_valid && !paging_en) begin
        e_paddr = PA_W'(lk_vaddr);
      end else if (lk_valid) begin
        found = 0;
        for (int i = 0; i < ENT; i++) begin
          if (!found && m_v[i] && m_vpn[i] == lk_vaddr[VA_W-1:12] &&
              (m_g[i] || m_ctx[i] == cur_ctx)) begin
            found = 1;
            e_paddr = {m_pfn[i], lk_vaddr[11:0]};
          end
        end
        e_hit = found; e_walk = !found;
      end
      take = fill_valid && !(inv_valid && inv_vpn == fill_vpn);
      slot = -1; evict = 0;
      for (int i = 0; i < ENT; i++) if (slot < 0 && !m_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; evict = 1; end
      if (base_write) for (int i = 0; i < ENT; i++) if (!m_g[i]) m_v[i] = 0;
      if (inv_valid)
        for (int i = 0; i < ENT; i++)
          if (m_v[i] && m_vpn[i] == inv_vpn && (m_g[i] || m_ctx[i] == cur_ctx)) m_v[i] = 0;
      if (take) begin
        m_v[slot] = 1; m_g[slot] = fill_global; m_vpn[slot] = fill_vpn;
        m_ctx[slot] = fill_ctx; m_pfn[slot] = fill_pfn;
        if (evict) m_rr = (m_rr + 1) % ENT;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      string tag;
      if (!e_valid) tag = "R11 model";
      else if (!paging_en && !e_hit && !e_walk) tag = "R10 model";
      else if (e_hit) tag = "R2 model";
      else tag = "R3 model";
      chk({tag, " valid"}, 64'(res_valid), 64'(e_valid));
      chk({tag, " hit"},   64'(res_hit),   64'(e_hit));
      chk({tag, " walk"},  64'(walk_req),  64'(e_walk));
      chk({tag, " paddr"}, 64'(res_paddr), 64'(e_paddr));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_inputs();
    lk_valid = 0; fill_valid = 0; inv_valid = 0; base_write = 0;
  endtask

  task automatic do_reset();
    rst = 1; idle_inputs(); paging_en = 1;
    repeat (3) step();
    rst = 0;
  endtask

  task automatic look(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                      input bit exp_hit, input logic [PA_W-1:0] exp_pa, input string tag);
    lk_valid = 1; lk_vaddr = va; cur_ctx = ctx;
    step();
    idle_inputs();
    chk({tag, " hit"},  64'(res_hit),  64'(exp_hit));
    chk({tag, " walk"}, 64'(walk_req), 64'(paging_en && !exp_hit));
    chk({tag, " paddr"}, 64'(res_paddr), 64'(exp_pa));
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [CTX_W-1:0] ctx,
                      input logic [PFN_W-1:0] pfn, input bit g);
    fill_valid = 1; fill_vpn = vpn; fill_ctx = ctx; fill_pfn = pfn; fill_global = g;
    step();
    idle_inputs();
  endtask

  task automatic inval(input logic [VPN_W-1:0] vpn, input logic [CTX_W-1:0] ctx);
    inv_valid = 1; inv_vpn = vpn; cur_ctx = ctx;
    step();
    idle_inputs();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: outputs clear and nothing hits after reset
    chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
    look(32'h0000_1000, 4'd1, 0, '0, "R1 empty miss");
    look(32'h0000_1000, 4'd1, 0, '0, "R3 miss paddr zero");

    // R5 and R2: fill then hit, offset passes through
    fill(20'h00001, 4'd1, 24'h0ABCDE, 0);
    look(32'h0000_1234, 4'd1, 1, 36'h0ABCDE234, "R2 hit translate");
    // R4: wrong context misses; global matches anywhere
    look(32'h0000_1234, 4'd2, 0, '0, "R4 ctx mismatch");
    fill(20'h00002, 4'd3, 24'h055555, 1);
    look(32'h0000_2FFF, 4'd7, 1, 36'h055555FFF, "R4 global any ctx");

    // R10: bypass
    paging_en = 0;
    look(32'hDEAD_BEEF, 4'd1, 0, 36'h0DEADBEEF, "R10 bypass");
    paging_en = 1;
    // R11: no lookup
    step();
    chk("R11 idle valid", 64'(res_valid), 64'd0);

    // R7: page invalidate scoped to context, global removed
    fill(20'h00003, 4'd2, 24'h033333, 0);
    inval(20'h00003, 4'd1);
    look(32'h0000_3000, 4'd2, 1, 36'h033333000, "R7 other ctx survives");
    inval(20'h00001, 4'd1);
    look(32'h0000_1000, 4'd1, 0, '0, "R7 own ctx removed");
    inval(20'h00002, 4'd5);
    look(32'h0000_2000, 4'd3, 0, '0, "R7 global removed");

    // R8: base write clears non-global, keeps global, same-cycle fill lands
    fill(20'h00004, 4'd0, 24'h044444, 1);
    base_write = 1;
    fill(20'h00005, 4'd1, 24'h0CAFE0, 0);
    look(32'h0000_3000, 4'd2, 0, '0, "R8 nonglobal flushed");
    look(32'h0000_4010, 4'd9, 1, 36'h044444010, "R8 global kept");
    look(32'h0000_5020, 4'd1, 1, 36'h0CAFE0020, "R8 same-cycle fill");

    // R9: fill and invalidate of same page collide
    inv_valid = 1; inv_vpn = 20'h00006; cur_ctx = 4'd1;
    fill(20'h00006, 4'd1, 24'h066666, 0);
    look(32'h0000_6000, 4'd1, 0, '0, "R9 fill dropped");

    // R6: round-robin replacement
    do_reset();
    fill(20'h00010, 4'd0, 24'h000010, 0);
    fill(20'h00011, 4'd0, 24'h000011, 0);
    fill(20'h00012, 4'd0, 24'h000012, 0);
    fill(20'h00013, 4'd0, 24'h000013, 0);
    fill(20'h00014, 4'd0, 24'h000014, 0);
    look(32'h0001_0000, 4'd0, 0, '0, "R6 slot0 evicted");
    look(32'h0001_1000, 4'd0, 1, 36'h000011000, "R6 slot1 kept");
    fill(20'h00015, 4'd0, 24'h000015, 0);
    look(32'h0001_1000, 4'd0, 0, '0, "R6 slot1 evicted");
    inval(20'h00013, 4'd0);
    fill(20'h00016, 4'd0, 24'h000016, 0);
    look(32'h0001_6000, 4'd0, 1, 36'h000016000, "R5 free slot reused");
    look(32'h0001_2000, 4'd0, 1, 36'h000012000, "R6 pointer held");
    fill(20'h00017, 4'd0, 24'h000017, 0);
    look(32'h0001_2000, 4'd0, 0, '0, "R6 slot2 evicted");
    look(32'h0001_4000, 4'd0, 1, 36'h000014000, "R6 slot0 kept");

    // Random phase, checked by the model on every clock
    for (int n = 0; n < 4000; n++) begin
      paging_en   = ($urandom % 8) != 0;
      lk_valid    = ($urandom % 4) != 0;
      lk_vaddr    = {17'd0, 3'($urandom % 8), 12'($urandom)};
      cur_ctx     = CTX_W'($urandom % 4);
      fill_valid  = ($urandom % 3) == 0;
      fill_vpn    = VPN_W'($urandom % 8);
      fill_ctx    = CTX_W'($urandom % 4);
      fill_pfn    = PFN_W'($urandom);
      fill_global = ($urandom % 4) == 0;
      inv_valid   = ($urandom % 6) == 0;
      inv_vpn     = VPN_W'($urandom % 8);
      base_write  = ($urandom % 20) == 0;
      step();
    end
    idle_inputs();
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule